// File: doc/BRIEF.md
# Conditional Set-and-Branch Unit

This block carries out one instruction that does two things: it tests the processor status flags against a 4-bit condition code, writes the outcome as the value 0 or 1 into a destination register, and steers the program counter. If the condition holds, the program counter moves by a signed 16-bit displacement. If it does not, execution falls through to the next instruction.

The condition code has two parts. Its low three bits pick which status flags take part in the test. Its top bit states the value each picked flag must have. The most significant status flag is always one, so the same code space also gives "always" and "never" conditions.

The caller strobes `start` with the operands of one instruction. Exactly one cycle later the unit presents a valid result: a register write request, the next program counter and a taken flag. The caller commits the write and the redirect together in that cycle.

Top module: `cond_branch_unit`

## Requirements
- R1: The status vector tested is {1, sign, zero}, with bit 2 hardwired to one, bit 1 taken from `flag_sign` and bit 0 from `flag_zero`. The condition holds when (status AND `cond[2:0]`) equals (`cond[3]` copied to three bits AND `cond[2:0]`).
- R2: Condition code 4'b1100 is always taken, and 4'b0100 is never taken, for every value of the two input flags.
- R3: `wr_data` is 32 bits wide and equals 1 when the condition holds and 0 when it fails. All of its upper 31 bits are always zero.
- R4: When the condition holds, `next_pc` equals `pc` + 4 + the sign-extended `offset`, with the sum taken modulo 2^32.
- R5: When the condition fails, `next_pc` equals `pc` + 4 and `taken` is 0.
- R6: `wr_en` stays low when `dest_idx` is 0 or 1. For indices 2 to 15 it is high in the result cycle, and `wr_idx` equals `dest_idx`.
- R7: `valid` is high exactly in the cycle after a cycle with `start` high, and `wr_en` is never high while `valid` is low.
- R8: After reset `valid`, `wr_en`, `taken`, `wr_idx`, `wr_data` and `next_pc` are all zero.
- R9: A taken instruction with offset 0 gives `taken` = 1 and `next_pc` = `pc` + 4, so it only sets the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Strobe: operands below are valid for one instruction |
| cond | input | 4 | Condition code: bit 3 polarity, bits 2..0 flag mask |
| flag_sign | input | 1 | Current sign flag |
| flag_zero | input | 1 | Current zero flag |
| dest_idx | input | 4 | Destination register index |
| offset | input | 16 | Signed branch displacement in bytes |
| pc | input | 32 | Address of the instruction being executed |
| valid | output | 1 | Result outputs are fresh this cycle |
| taken | output | 1 | Condition held |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 4 | Register index to write |
| wr_data | output | 32 | Value to write: 0 or 1 |
| next_pc | output | 32 | Address of the next instruction |

## Verification
The register write and the control-flow redirect come out in the same result cycle. A single instruction with a writable destination and a true condition therefore raises both `wr_en` with data 1 and a displaced `next_pc`. The bench sweeps every condition code against every flag pair while it rotates the destination through all sixteen indices and the offset through zero, positive, most negative and most positive values. In each result cycle it judges the write fields and the next address together against values it computes from the flag formula.

// File: rtl/cbu_pkg.sv
// Package: shared constants of the conditional set-and-branch unit.
// Assumes a fixed 4-byte instruction and a 3-bit status field whose top bit is constant one.
package cbu_pkg;
    localparam int COND_W      = 4;
    localparam int STAT_W      = COND_W - 1;
    localparam int INSN_BYTES  = 4;
    localparam int RO_REGS     = 2;
endpackage

// File: rtl/cbu_cond_eval.sv
// Module: evaluates the condition code against the status vector.
// Each mask bit that is set demands that its status bit equal the polarity bit.
// Assumes the caller has already built the full status vector.
module cbu_cond_eval
    import cbu_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [STAT_W-1:0] status,
    output logic              hit
);
    logic [STAT_W-1:0] bit_ok;

    // One term per status bit: unmasked bits always agree.
    for (genvar i = 0; i < STAT_W; i++) begin : g_term
        assign bit_ok[i] = ~cond[i] | (status[i] == cond[COND_W-1]);
    end

    // Condition holds only when every term agrees.
    always_comb hit = &bit_ok;
endmodule

// File: rtl/cbu_target_calc.sv
// Module: computes the fall-through and displaced next addresses.
// Assumes the offset is signed and relative to the end of the instruction.
module cbu_target_calc
    import cbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFS_W-1:0]  offset,
    input  logic              hit,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] ofs_ext;

    // Sequential address past the whole instruction.
    always_comb seq_pc = pc + ADDR_W'(INSN_BYTES);

    // Sign extension of the displacement.
    always_comb ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};

    // Choose the displaced or the sequential address.
    always_comb target = hit ? seq_pc + ofs_ext : seq_pc;
endmodule

// File: rtl/cbu_wr_gate.sv
// Module: decides whether a register write may leave the unit.
// Assumes indices below RO_REGS are constant registers that must never be written.
module cbu_wr_gate
    import cbu_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] dest_idx,
    output logic             writable
);
    // Indices below the read-only limit are refused.
    always_comb writable = (dest_idx >= IDX_W'(RO_REGS));
endmodule

// File: rtl/cond_branch_unit.sv
// Module: top of the conditional set-and-branch unit.
// Captures one instruction per start strobe and presents a registered result one cycle later.
// Assumes the caller samples outputs only while valid is high; data outputs hold between results.
module cond_branch_unit
    import cbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COND_W-1:0] cond,
    input  logic              flag_sign,
    input  logic              flag_zero,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [OFS_W-1:0]  offset,
    input  logic [ADDR_W-1:0] pc,
    output logic              valid,
    output logic              taken,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] next_pc
);
    logic [STAT_W-1:0] status;
    logic              hit;
    logic              writable;
    logic [ADDR_W-1:0] target;

    // Status vector with its constant-one top bit.
    always_comb status = {1'b1, flag_sign, flag_zero};

    cbu_cond_eval u_eval (
        .cond   (cond),
        .status (status),
        .hit    (hit)
    );

    cbu_target_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_target (
        .pc     (pc),
        .offset (offset),
        .hit    (hit),
        .target (target)
    );

    cbu_wr_gate #(.IDX_W(IDX_W)) u_gate (
        .dest_idx (dest_idx),
        .writable (writable)
    );

    // Result register: pulses valid/wr_en, holds data fields until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            taken   <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            next_pc <= '0;
        end else begin
            valid <= start;
            wr_en <= start & writable;
            if (start) begin
                taken   <= hit;
                wr_idx  <= dest_idx;
                wr_data <= {{(DATA_W-1){1'b0}}, hit};
                next_pc <= target;
            end
        end
    end
endmodule

// File: rtl/cond_branch_unit_chk.sv
// Module: temporal checks on the unit's ports, bound to every instance of the top.
module cond_branch_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        cond,
    input logic [ADDR_W-1:0] pc,
    input logic              valid,
    input logic              taken,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] next_pc
);
    // R7
    result_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    // R7
    no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    // R7
    write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> valid);
    // R6
    const_reg_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx > IDX_W'(1)));
    // R2
    always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cond == 4'b1100) |=> taken);
    // R2
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cond == 4'b0100) |=> !taken);
    // R3
    boolean_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (wr_data == DATA_W'(taken)));
    // R5
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !taken) |-> (next_pc == $past(pc) + ADDR_W'(4)));
endmodule

bind cond_branch_unit cond_branch_unit_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cond(cond), .pc(pc),
    .valid(valid), .taken(taken), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .next_pc(next_pc)
);

// File: tb/cond_branch_unit_test.sv
// Bench: sweeps every condition code against every flag pair and checks results arithmetically.
module cond_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cond = '0;
    logic        flag_sign = 1'b0;
    logic        flag_zero = 1'b0;
    logic [3:0]  dest_idx = '0;
    logic [15:0] offset = '0;
    logic [31:0] pc = '0;
    logic        valid, taken, wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data, next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cond_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .dest_idx(dest_idx),
        .offset(offset), .pc(pc), .valid(valid), .taken(taken), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .next_pc(next_pc)
    );

    // Records one comparison; prints a line only on mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issues one instruction and checks its result cycle.
    task automatic issue(input logic [3:0] c, input logic [1:0] f, input logic [3:0] d,
                         input logic [15:0] o, input logic [31:0] p);
        logic [2:0]  stat;
        logic        exp_hit;
        logic [31:0] exp_pc;
        stat    = {1'b1, f};
        exp_hit = ((stat & c[2:0]) == ({3{c[3]}} & c[2:0]));
        exp_pc  = exp_hit ? p + 32'd4 + {{16{o[15]}}, o} : p + 32'd4;
        @(negedge clk);
        start = 1'b1; cond = c; flag_sign = f[1]; flag_zero = f[0];
        dest_idx = d; offset = o; pc = p;
        @(negedge clk);
        start = 1'b0;
        check("R7 valid", 32'(valid), 32'd1);
        check("R1 taken", 32'(taken), 32'(exp_hit));
        if (exp_hit) check("R4 next_pc", next_pc, exp_pc);
        else         check("R5 next_pc", next_pc, exp_pc);
        check("R3 wr_data", wr_data, 32'(exp_hit));
        check("R6 wr_en", 32'(wr_en), 32'(d > 4'd1));
        if (d > 4'd1) check("R6 wr_idx", 32'(wr_idx), 32'(d));
    endtask

    initial begin
        logic [15:0] ofs_set [4];
        ofs_set[0] = 16'h0000; ofs_set[1] = 16'h0010;
        ofs_set[2] = 16'h8000; ofs_set[3] = 16'h7FFF;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid", 32'(valid), 32'd0);
        check("R8 wr_en", 32'(wr_en), 32'd0);
        check("R8 taken", 32'(taken), 32'd0);
        check("R8 wr_idx", 32'(wr_idx), 32'd0);
        check("R8 wr_data", wr_data, 32'd0);
        check("R8 next_pc", next_pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle valid", 32'(valid), 32'd0);
        // R1, R3, R4, R5, R6: full sweep of codes and flags
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 4; f++) begin
                issue(4'(c), 2'(f), 4'(c + f), ofs_set[(c + f) % 4],
                      32'h1000_0000 + 32'(c * 256 + f * 2));
            end
        end
        // R2: always and never codes under every flag pair
        for (int f = 0; f < 4; f++) begin
            issue(4'b1100, 2'(f), 4'd5, 16'h0020, 32'h0000_0100);
            check("R2 always", 32'(taken), 32'd1);
            issue(4'b0100, 2'(f), 4'd5, 16'h0020, 32'h0000_0100);
            check("R2 never", 32'(taken), 32'd0);
        end
        // R9: set-only with zero offset
        issue(4'b1100, 2'b00, 4'd7, 16'h0000, 32'h0000_4000);
        check("R9 taken", 32'(taken), 32'd1);
        check("R9 next_pc", next_pc, 32'h0000_4004);
        // R4: wrap below address zero
        issue(4'b1100, 2'b00, 4'd1, 16'hFFF0, 32'h0000_0004);
        check("R4 wrap", next_pc, 32'hFFFF_FFF8);
        // R7: pulse drops after the result cycle
        @(negedge clk);
        check("R7 valid drop", 32'(valid), 32'd0);
        check("R7 wr_en drop", 32'(wr_en), 32'd0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule